// File: doc/BRIEF.md
# Simulation Finisher Control Register

This peripheral sits on a simple register bus and gives software on a simulated processor a single control word it can write to end the run or to ask for a system reset. One 32-bit write carries a 16-bit command in its low half and a 16-bit exit code in its high half. A pass or fail command latches sticky terminate outputs that the surrounding harness watches. A reset command produces a one-cycle request to the system reset logic. Every write the block does not understand produces a one-cycle error pulse.

The block decodes a 4 KiB window in which only offset 0 acts on writes. Reads anywhere return zero. Every access completes in the cycle it is presented, with no wait states. Accesses must be 2 or 4 bytes wide. Once the run has been marked finished, the block ignores further writes until reset.

Top module: `sim_finisher`

## Requirements
- R1: During every access (`acc_sel` high), `acc_ready` is high in the same cycle and `acc_rdata` is zero.
- R2: A 4-byte write to offset 0 whose bits 15:0 equal 0x3333 (fail) sets `run_done` high, `run_ok` low and `exit_code` to bits 31:16, from the cycle after the write.
- R3: A write to offset 0 whose bits 15:0 equal 0x5555 (pass) sets `run_done` and `run_ok` high with `exit_code` zero, whatever bits 31:16 hold.
- R4: A write to offset 0 whose bits 15:0 equal 0x7777 raises `sys_rst_req` for exactly the one cycle after the write and leaves `run_done`, `run_ok` and `exit_code` unchanged.
- R5: A legal-size write to offset 0 whose bits 15:0 match none of the three commands raises `bad_access` for the one cycle after it and has no other effect.
- R6: A legal-size write to any nonzero offset raises `bad_access` for the one cycle after it and has no other effect.
- R7: Any access, read or write, whose `acc_size` is neither 2 nor 4 raises `bad_access` for the one cycle after it and has no other effect.
- R8: A 2-byte write to offset 0 takes its command from bits 15:0 and uses zero as the exit code, so a 2-byte fail leaves `exit_code` at zero.
- R9: Once `run_done` is high, `run_done`, `run_ok` and `exit_code` hold until reset, and writes of legal size produce no `sys_rst_req` and no `bad_access`.
- R10: While and after reset, `run_done`, `run_ok`, `exit_code`, `sys_rst_req` and `bad_access` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_sel | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Byte offset within the window |
| acc_wdata | input | 32 | Write data: command in 15:0, exit code in 31:16 |
| acc_size | input | 3 | Access width in bytes |
| acc_rdata | output | 32 | Read data, always zero |
| acc_ready | output | 1 | Access complete this cycle |
| run_done | output | 1 | Sticky: a pass or fail was written |
| run_ok | output | 1 | Sticky: the finishing command was pass |
| exit_code | output | 16 | Sticky exit code of the run |
| sys_rst_req | output | 1 | One-cycle system reset request |
| bad_access | output | 1 | One-cycle flag for an unrecognised access |

## Verification
The embedded assertions watch on every cycle that the terminate outputs never change once set, that a pass always carries a zero exit code, that a reset request and an error never coincide, that a reset request only follows a reset command written before the run finished, and that illegal sizes and stray offsets always raise the error flag. The bench's scenarios are needed to show the values themselves: that a fail carries exactly bits 31:16, that a 2-byte fail gives a zero code, that unknown commands leave the sticky state untouched, and that the lockout after a finish holds across a mix of random writes.

// File: rtl/finisher_pkg.sv
package finisher_pkg;
  localparam int unsigned STAT_W = 16;

  localparam logic [STAT_W-1:0] ST_FAIL  = 16'h3333;
  localparam logic [STAT_W-1:0] ST_PASS  = 16'h5555;
  localparam logic [STAT_W-1:0] ST_RESET = 16'h7777;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_FAIL  = 3'd1,
    CMD_PASS  = 3'd2,
    CMD_RESET = 3'd3,
    CMD_ERROR = 3'd4
  } cmd_e;
endpackage

// File: rtl/finisher_decode.sv
module finisher_decode
  import finisher_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned SIZE_W = 3,
  localparam int unsigned DATA_W = 2 * STAT_W
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SIZE_W-1:0] size,
  input  logic              locked,
  output cmd_e              cmd,
  output logic [STAT_W-1:0] code
);
  logic              size_ok;
  logic              full_word;
  logic [STAT_W-1:0] status;

  assign size_ok   = (size == SIZE_W'(2)) || (size == SIZE_W'(4));
  assign full_word = (size == SIZE_W'(4));
  assign status    = wdata[STAT_W-1:0];

  always_comb begin
    cmd  = CMD_NONE;
    code = full_word ? wdata[DATA_W-1:STAT_W] : '0;
    if (sel) begin
      if (!size_ok) begin
        cmd = CMD_ERROR;
      end else if (wr && !locked) begin
        if (addr != '0) begin
          cmd = CMD_ERROR;
        end else begin
          case (status)
            ST_FAIL:  cmd = CMD_FAIL;
            ST_PASS:  cmd = CMD_PASS;
            ST_RESET: cmd = CMD_RESET;
            default:  cmd = CMD_ERROR;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/finisher_state.sv
module finisher_state
  import finisher_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic [STAT_W-1:0] code,
  output logic              done,
  output logic              ok,
  output logic [STAT_W-1:0] code_q,
  output logic              rst_req,
  output logic              err
);
  logic              done_d, ok_d, rst_req_d, err_d;
  logic [STAT_W-1:0] code_d;
  logic              upd_en;

  always_comb begin
    done_d    = done;
    ok_d      = ok;
    code_d    = code_q;
    rst_req_d = 1'b0;
    err_d     = 1'b0;
    upd_en    = 1'b0;
    case (cmd)
      CMD_FAIL: begin
        upd_en = 1'b1;
        done_d = 1'b1;
        ok_d   = 1'b0;
        code_d = code;
      end
      CMD_PASS: begin
        upd_en = 1'b1;
        done_d = 1'b1;
        ok_d   = 1'b1;
        code_d = '0;
      end
      CMD_RESET: rst_req_d = 1'b1;
      CMD_ERROR: err_d     = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      ok     <= 1'b0;
      code_q <= '0;
    end else if (upd_en) begin
      done   <= done_d;
      ok     <= ok_d;
      code_q <= code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      err     <= 1'b0;
    end else begin
      rst_req <= rst_req_d;
      err     <= err_d;
    end
  end

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && $stable(ok) && $stable(code_q));

  assert_pass_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> done && (code_q == '0));

  assert_pulse_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && err));

  assert_no_req_when_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !$past(done));
endmodule

// File: rtl/sim_finisher.sv
module sim_finisher
  import finisher_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_sel,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  input  logic [SIZE_W-1:0] acc_size,
  output logic [31:0]       acc_rdata,
  output logic              acc_ready,
  output logic              run_done,
  output logic              run_ok,
  output logic [15:0]       exit_code,
  output logic              sys_rst_req,
  output logic              bad_access
);
  cmd_e              cmd;
  logic [STAT_W-1:0] cmd_code;

  assign acc_ready = acc_sel;
  assign acc_rdata = '0;

  finisher_decode #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_decode (
    .sel    (acc_sel),
    .wr     (acc_wr),
    .addr   (acc_addr),
    .wdata  (acc_wdata),
    .size   (acc_size),
    .locked (run_done),
    .cmd    (cmd),
    .code   (cmd_code)
  );

  finisher_state u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .code    (cmd_code),
    .done    (run_done),
    .ok      (run_ok),
    .code_q  (exit_code),
    .rst_req (sys_rst_req),
    .err     (bad_access)
  );

  assert_bad_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sel && (acc_size != SIZE_W'(2)) && (acc_size != SIZE_W'(4)))
      |=> bad_access && $stable(run_done));

  assert_bad_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sel && acc_wr && !run_done && (acc_addr != '0) &&
     ((acc_size == SIZE_W'(2)) || (acc_size == SIZE_W'(4))))
      |=> bad_access && !run_done);

  assert_locked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_done && acc_sel && acc_wr &&
     ((acc_size == SIZE_W'(2)) || (acc_size == SIZE_W'(4))))
      |=> !bad_access && !sys_rst_req);
endmodule

// File: tb/sim_finisher_test.sv
`timescale 1ns/1ps
module sim_finisher_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_sel, acc_wr;
  logic [11:0] acc_addr;
  logic [31:0] acc_wdata, acc_rdata;
  logic [2:0]  acc_size;
  logic        acc_ready, run_done, run_ok, sys_rst_req, bad_access;
  logic [15:0] exit_code;

  int n_run = 0;
  int n_bad = 0;

  logic        m_done, m_ok;
  logic [15:0] m_code;

  always #10 clk = ~clk;

  sim_finisher uut (
    .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_size(acc_size),
    .acc_rdata(acc_rdata), .acc_ready(acc_ready), .run_done(run_done),
    .run_ok(run_ok), .exit_code(exit_code), .sys_rst_req(sys_rst_req),
    .bad_access(bad_access)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // 0 none, 1 fail, 2 pass, 3 reset, 4 error
  function automatic int model_cmd(logic sel, logic wr, logic [11:0] a, logic [31:0] d, logic [2:0] s, logic locked);
    if (!sel) return 0;
    if (!(s == 3'd2 || s == 3'd4)) return 4;
    if (!wr || locked) return 0;
    if (a != 12'd0) return 4;
    if (d[15:0] == 16'h3333) return 1;
    if (d[15:0] == 16'h5555) return 2;
    if (d[15:0] == 16'h7777) return 3;
    return 4;
  endfunction

  function automatic string req_of(int c, logic locked, logic [2:0] s, logic [11:0] a);
    if (c == 1) return (s == 3'd2) ? "R8" : "R2";
    if (c == 2) return "R3";
    if (c == 3) return "R4";
    if (c == 4) return !(s == 3'd2 || s == 3'd4) ? "R7" : (a != 0 ? "R6" : "R5");
    return locked ? "R9" : "R1";
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; acc_sel = 1'b0; acc_wr = 1'b0;
    acc_addr = '0; acc_wdata = '0; acc_size = 3'd4;
    #1;
    chk({run_done, run_ok, exit_code, sys_rst_req, bad_access} == 20'd0, "R10",
        64'({run_done, run_ok, exit_code, sys_rst_req, bad_access}), 64'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_done = 1'b0; m_ok = 1'b0; m_code = '0;
    @(posedge clk); #1;
    chk({run_done, run_ok, exit_code, sys_rst_req, bad_access} == 20'd0, "R10",
        64'({run_done, run_ok, exit_code, sys_rst_req, bad_access}), 64'd0);
  endtask

  task automatic do_acc(input logic wr, input logic [11:0] a, input logic [31:0] d, input logic [2:0] s);
    int c;
    logic exp_req, exp_err;
    logic [19:0] exp_v, act_v;
    string r;
    @(negedge clk);
    acc_sel = 1'b1; acc_wr = wr; acc_addr = a; acc_wdata = d; acc_size = s;
    #1;
    chk(acc_ready === 1'b1 && acc_rdata === 32'd0, "R1",
        64'({acc_ready, acc_rdata}), 64'({1'b1, 32'd0}));
    c = model_cmd(1'b1, wr, a, d, s, m_done);
    r = req_of(c, m_done, s, a);
    exp_req = (c == 3);
    exp_err = (c == 4);
    if (c == 1) begin m_done = 1'b1; m_ok = 1'b0; m_code = (s == 3'd4) ? d[31:16] : 16'd0; end
    if (c == 2) begin m_done = 1'b1; m_ok = 1'b1; m_code = 16'd0; end
    @(posedge clk); #1;
    acc_sel = 1'b0;
    exp_v = {m_done, m_ok, m_code, exp_req, exp_err};
    act_v = {run_done, run_ok, exit_code, sys_rst_req, bad_access};
    chk(act_v === exp_v, r, 64'(act_v), 64'(exp_v));
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    do_reset();
    // R1: read returns zero
    do_acc(1'b0, 12'h000, 32'd0, 3'd4);
    // R7: illegal sizes, read and write
    do_acc(1'b0, 12'h010, 32'd0, 3'd1);
    do_acc(1'b1, 12'h000, 32'h0000_5555, 3'd1);
    do_acc(1'b1, 12'h000, 32'h0000_3333, 3'd8 - 3'd5);
    // R6: stray offset with a pass pattern
    do_acc(1'b1, 12'h004, 32'h0000_5555, 3'd4);
    do_acc(1'b1, 12'hFFC, 32'h0000_3333, 3'd2);
    // R5: unknown command
    do_acc(1'b1, 12'h000, 32'h1234_3334, 3'd4);
    // R4: reset request, back to back
    do_acc(1'b1, 12'h000, 32'hABCD_7777, 3'd4);
    do_acc(1'b1, 12'h000, 32'h0000_7777, 3'd2);
    // R2: fail with code
    do_acc(1'b1, 12'h000, 32'hBEEF_3333, 3'd4);
    // R9: later writes ignored
    do_acc(1'b1, 12'h000, 32'h0000_5555, 3'd4);
    do_acc(1'b1, 12'h000, 32'h0000_7777, 3'd4);
    do_acc(1'b1, 12'h008, 32'h0000_0000, 3'd4);
    do_acc(1'b1, 12'h000, 32'h0000_0000, 3'd3);
    do_reset();
    // R3: pass ignores upper half
    do_acc(1'b1, 12'h000, 32'hFFFF_5555, 3'd4);
    do_reset();
    // R8: 2-byte fail, code zero
    do_acc(1'b1, 12'h000, 32'h9999_3333, 3'd2);
    do_reset();
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d;
      logic [11:0] a;
      logic [2:0]  s;
      logic        w;
      int          p;
      if (i % 25 == 24) do_reset();
      p = int'($urandom % 8);
      case (p)
        0, 1:    d = {$urandom_range(65535, 0) , 16'h3333} ;
        2:       d = {16'($urandom), 16'h5555};
        3, 4:    d = {16'($urandom), 16'h7777};
        default: d = $urandom;
      endcase
      a = ($urandom % 4 == 0) ? 12'($urandom) : 12'h000;
      s = ($urandom % 3 == 0) ? 3'($urandom) : (($urandom % 2 == 0) ? 3'd4 : 3'd2);
      w = ($urandom % 5 != 0);
      do_acc(w, a, d, s);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule